// File: doc/BRIEF.md
# DMA standby state controller

This block manages the operating state of a descriptor-driven DMA controller. It keeps one of four states: normal, a one-cycle entry state (transition 1), a drain state (transition 2) and standby. In normal operation it accepts command writes, software-trigger writes, hardware descriptor pointer writes and completion or error events from the transfer engine. From these it keeps the software start bit, the software, per-channel hardware and error interrupt lines, the per-channel hardware request masks and the error status record.

A standby-entry command quiets the controller in a single edge. It drops every interrupt and the software start bit and sets every hardware request mask. It then takes a snapshot of the engine's busy flags and forcibly ends each in-flight transfer. For each one it issues a descriptor-close request carrying a termination status and holds that request until the engine acknowledges it. The error status keeps its value through standby, so software can read it there. It can only be cleared after a standby-release command has brought the controller back to normal.

Top module: `dma_standby_ctrl`

## Requirements
- R1: After reset the state is normal (`state` = 2'd0), all masks, interrupts, the start bit, the error status and the pointer registers are zero, and no close request is raised.
- R2: A standby-entry command (`cmd_code` 3'd1 with `cmd_valid`) in normal moves the state to transition 1 (2'd1) at the next edge. At that same edge it clears `sw_start`, `sw_irq`, every `hw_irq` bit and `err_irq`, sets every `hw_mask` bit, and leaves `err_stat` unchanged.
- R3: Transition 1 lasts exactly one cycle and is followed by transition 2 (2'd2). In transition 2 with nothing to close, the state becomes standby (2'd3) at the next edge.
- R4: On leaving transition 1 the controller captures `hw_busy`, `hw_ch` and `sw_busy`. In transition 2 it raises `close_req` with `close_code` 2'b11 for each captured transfer: the hardware transfer first (`close_sw`=0, `close_ch` = captured channel), then the software transfer (`close_sw`=1, `close_ch`=0). Each request is held unchanged until `close_ack` is seen.
- R5: Each acknowledged close sets `err_stat` to 3'b011. Once the last close is acknowledged, standby is entered at the following edge.
- R6: A standby-release command (3'd2) in standby returns the state to normal at the next edge, and the masks stay set.
- R7: The error-clear command (3'd4) zeroes `err_stat` and `err_irq` in normal only. In any other state it is ignored and `err_stat` stays readable.
- R8: A software-trigger write (`swtr_wr`) sets `sw_start` in normal only. In any other state it is ignored.
- R9: The mask-clear command (3'd5) clears the `hw_mask` bits selected by `cmd_arg`, and `hdp_wr` stores `hdp_wdata` into pointer `hdp_sel`. Both act in normal only. `hdp_rdata` shows the selected pointer in normal and reads 0 otherwise.
- R10: `hw_req_out` equals `hw_req_in & ~hw_mask` in normal and is 0 in every other state.
- R11: In normal, `hw_done[n]` sets `hw_irq[n]`, and `sw_done` sets `sw_irq` and clears `sw_start`, taking precedence over a same-cycle trigger write. `err_evt` loads `err_code` into `err_stat` and sets `err_irq`. The software-clear (3'd3) and error-clear commands take precedence over same-cycle set events. All of these events are ignored outside normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command register write strobe |
| cmd_code | input | 3 | Command: 1 entry, 2 release, 3 sw clear, 4 error clear, 5 mask clear |
| cmd_arg | input | NCH | Channel bits for mask clear |
| swtr_wr | input | 1 | Software trigger write |
| sw_busy | input | 1 | Software transfer in flight |
| sw_done | input | 1 | Software transfer completed |
| hw_busy | input | 1 | Hardware transfer in flight |
| hw_ch | input | $clog2(NCH) | Channel of the hardware transfer |
| hw_done | input | NCH | Per-channel hardware completion |
| hw_req_in | input | NCH | Raw hardware requests |
| err_evt | input | 1 | Transfer error event |
| err_code | input | 3 | Error code for the event |
| hdp_wr | input | 1 | Hardware descriptor pointer write |
| hdp_sel | input | $clog2(NCH) | Pointer select |
| hdp_wdata | input | PW | Pointer write data |
| close_ack | input | 1 | Engine acknowledges a close |
| state | output | 2 | 0 normal, 1 transition 1, 2 transition 2, 3 standby |
| sw_start | output | 1 | Software start bit |
| sw_irq | output | 1 | Software interrupt |
| hw_irq | output | NCH | Per-channel hardware interrupts |
| err_irq | output | 1 | Error interrupt |
| hw_mask | output | NCH | Hardware request masks |
| err_stat | output | 3 | Error status record |
| hw_req_out | output | NCH | Requests passed to the engine |
| hdp_rdata | output | PW | Selected pointer read data |
| close_req | output | 1 | Descriptor-close request |
| close_sw | output | 1 | Close targets the software transfer |
| close_ch | output | $clog2(NCH) | Channel of the close |
| close_code | output | 2 | Termination status written by the close |

## Verification
Directed sequences cover the drain with both transfers busy, with the acknowledge held back and then given. This shows the hardware-first ordering and the hold of an unacknowledged request apart from a request that drops or reorders early. Standby is also probed with error-clear, mask-clear, trigger and pointer writes; their effects are read back after release, which separates true ignoring from delayed action. Random command, event, busy and acknowledge patterns across thousands of cycles are compared each cycle with a bench model. That comparison catches wrong precedence between same-cycle set and clear events and masks that leak requests in any state.

// File: rtl/dma_standby_ctrl.sv
module dma_standby_ctrl #(
  parameter int NCH = 4,
  parameter int PW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_code,
  input  logic [NCH-1:0]           cmd_arg,
  input  logic                     swtr_wr,
  input  logic                     sw_busy,
  input  logic                     sw_done,
  input  logic                     hw_busy,
  input  logic [$clog2(NCH)-1:0]   hw_ch,
  input  logic [NCH-1:0]           hw_done,
  input  logic [NCH-1:0]           hw_req_in,
  input  logic                     err_evt,
  input  logic [2:0]               err_code,
  input  logic                     hdp_wr,
  input  logic [$clog2(NCH)-1:0]   hdp_sel,
  input  logic [PW-1:0]            hdp_wdata,
  input  logic                     close_ack,
  output logic [1:0]               state,
  output logic                     sw_start,
  output logic                     sw_irq,
  output logic [NCH-1:0]           hw_irq,
  output logic                     err_irq,
  output logic [NCH-1:0]           hw_mask,
  output logic [2:0]               err_stat,
  output logic [NCH-1:0]           hw_req_out,
  output logic [PW-1:0]            hdp_rdata,
  output logic                     close_req,
  output logic                     close_sw,
  output logic [$clog2(NCH)-1:0]   close_ch,
  output logic [1:0]               close_code
);
  localparam int CW = $clog2(NCH);
  localparam logic [1:0] S_NORM = 2'd0, S_TR1 = 2'd1, S_TR2 = 2'd2, S_SBY = 2'd3;
  localparam logic [2:0] C_ENTER = 3'd1, C_REL = 3'd2, C_SWCLR = 3'd3, C_ERCLR = 3'd4, C_MKCLR = 3'd5;

  logic [1:0]    st;
  logic          hp, sp;
  logic [CW-1:0] pch;
  logic [PW-1:0] hdp [NCH];

  wire normal = (st == S_NORM);
  wire enter  = normal && cmd_valid && cmd_code == C_ENTER;
  wire swclr  = cmd_valid && cmd_code == C_SWCLR;
  wire erclr  = cmd_valid && cmd_code == C_ERCLR;
  wire mkclr  = cmd_valid && cmd_code == C_MKCLR;
  wire ack_ok = close_req && close_ack;

  assign state      = st;
  assign close_req  = (st == S_TR2) && (hp || sp);
  assign close_sw   = !hp;
  assign close_ch   = hp ? pch : '0;
  assign close_code = 2'b11;
  assign hw_req_out = normal ? (hw_req_in & ~hw_mask) : '0;
  assign hdp_rdata  = normal ? hdp[hdp_sel] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_NORM; hp <= 1'b0; sp <= 1'b0; pch <= '0;
    end else begin
      case (st)
        S_NORM: if (enter) st <= S_TR1;
        S_TR1: begin st <= S_TR2; hp <= hw_busy; sp <= sw_busy; pch <= hw_ch; end
        S_TR2: begin
          if (!hp && !sp) st <= S_SBY;
          else if (close_ack) begin
            if (hp) hp <= 1'b0;
            else    sp <= 1'b0;
          end
        end
        default: if (cmd_valid && cmd_code == C_REL) st <= S_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_start <= 1'b0; sw_irq <= 1'b0; hw_irq <= '0; err_irq <= 1'b0;
      hw_mask <= '0; err_stat <= '0;
    end else if (normal) begin
      if (enter) begin
        sw_start <= 1'b0; sw_irq <= 1'b0; hw_irq <= '0; err_irq <= 1'b0; hw_mask <= '1;
      end else begin
        if (sw_done) sw_start <= 1'b0;
        else if (swtr_wr) sw_start <= 1'b1;
        sw_irq <= (sw_irq | sw_done) & !swclr;
        hw_irq <= hw_irq | hw_done;
        if (erclr) begin
          err_stat <= '0; err_irq <= 1'b0;
        end else if (err_evt) begin
          err_stat <= err_code; err_irq <= 1'b1;
        end
        if (mkclr) hw_mask <= hw_mask & ~cmd_arg;
      end
    end else if (ack_ok) begin
      err_stat <= 3'b011;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) hdp[i] <= '0;
    end else if (normal && !enter && hdp_wr) begin
      hdp[hdp_sel] <= hdp_wdata;
    end
  end

  a_r2_enter_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (st == S_TR1) && !sw_start && !sw_irq && hw_irq == '0 && !err_irq && &hw_mask && $stable(err_stat));
  a_r3_tr1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TR1 |=> st == S_TR2);
  a_r4_close_held: assert property (@(posedge clk) disable iff (!rst_n)
    close_req && !close_ack |=> close_req && $stable(close_sw) && $stable(close_ch));
  a_r4_close_only_tr2: assert property (@(posedge clk) disable iff (!rst_n)
    close_req |-> st == S_TR2);
  a_r5_ack_code: assert property (@(posedge clk) disable iff (!rst_n)
    close_req && close_ack |=> err_stat == 3'b011);
  a_r6_masks_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SBY |-> &hw_mask);
  a_r7_err_kept_standby: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SBY |=> $stable(err_stat));
  a_r10_no_req_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !normal |-> hw_req_out == '0);
  a_r11_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !normal |-> !sw_irq && !err_irq && hw_irq == '0 && !sw_start);
endmodule

// File: tb/dma_standby_ctrl_test.sv
`timescale 1ns/1ps
module dma_standby_ctrl_test;
  localparam int NCH = 4, PW = 16, CW = 2;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0; logic [2:0] cmd_code = 0; logic [NCH-1:0] cmd_arg = 0;
  logic swtr_wr = 0, sw_busy = 0, sw_done = 0, hw_busy = 0;
  logic [CW-1:0] hw_ch = 0; logic [NCH-1:0] hw_done = 0, hw_req_in = 0;
  logic err_evt = 0; logic [2:0] err_code = 0;
  logic hdp_wr = 0; logic [CW-1:0] hdp_sel = 0; logic [PW-1:0] hdp_wdata = 0;
  logic close_ack = 0;
  logic [1:0] state; logic sw_start, sw_irq, err_irq, close_req, close_sw;
  logic [NCH-1:0] hw_irq, hw_mask, hw_req_out; logic [2:0] err_stat;
  logic [PW-1:0] hdp_rdata; logic [CW-1:0] close_ch; logic [1:0] close_code;

  dma_standby_ctrl #(.NCH(NCH), .PW(PW)) uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_st; logic m_hp, m_sp, m_start, m_swi, m_eri; logic [CW-1:0] m_pch;
  logic [NCH-1:0] m_hwi, m_mask; logic [2:0] m_est; logic [PW-1:0] m_hdp [NCH];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic m_reset();
    m_st = 0; m_hp = 0; m_sp = 0; m_pch = 0; m_start = 0; m_swi = 0; m_eri = 0;
    m_hwi = 0; m_mask = 0; m_est = 0;
    for (int i = 0; i < NCH; i++) m_hdp[i] = 0;
  endtask

  task automatic m_step();
    bit c = cmd_valid;
    case (m_st)
      0: if (c && cmd_code == 1) begin
           m_st = 1; m_start = 0; m_swi = 0; m_hwi = 0; m_eri = 0; m_mask = '1;
         end else begin
           if (sw_done) m_start = 0; else if (swtr_wr) m_start = 1;
           m_swi = (m_swi | sw_done) & !(c && cmd_code == 3);
           m_hwi = m_hwi | hw_done;
           if (c && cmd_code == 4) begin m_est = 0; m_eri = 0; end
           else if (err_evt) begin m_est = err_code; m_eri = 1; end
           if (c && cmd_code == 5) m_mask = m_mask & ~cmd_arg;
           if (hdp_wr) m_hdp[hdp_sel] = hdp_wdata;
         end
      1: begin m_st = 2; m_hp = hw_busy; m_sp = sw_busy; m_pch = hw_ch; end
      2: if (!m_hp && !m_sp) m_st = 3;
         else if (close_ack) begin m_est = 3'b011; if (m_hp) m_hp = 0; else m_sp = 0; end
      default: if (c && cmd_code == 2) m_st = 0;
    endcase
  endtask

  task automatic cmp_all();
    logic [NCH-1:0] er = (m_st == 0) ? (hw_req_in & ~m_mask) : '0;
    logic [PW-1:0] ed = (m_st == 0) ? m_hdp[hdp_sel] : '0;
    bit ecr = (m_st == 2) && (m_hp || m_sp);
    chk(state == m_st, "R3 state", state, m_st);
    chk({sw_start, sw_irq, hw_irq, err_irq} == {m_start, m_swi, m_hwi, m_eri}, "R11 irq/start",
        {sw_start, sw_irq, hw_irq, err_irq}, {m_start, m_swi, m_hwi, m_eri});
    chk(hw_mask == m_mask, "R9 mask", hw_mask, m_mask);
    chk(err_stat == m_est, "R5 err_stat", err_stat, m_est);
    chk(close_req == ecr, "R4 close_req", close_req, ecr);
    if (ecr) chk({close_sw, close_ch, close_code} == {!m_hp, m_hp ? m_pch : 2'd0, 2'b11}, "R4 close fields",
                 {close_sw, close_ch, close_code}, {!m_hp, m_hp ? m_pch : 2'd0, 2'b11});
    chk(hw_req_out == er, "R10 req_out", hw_req_out, er);
    chk(hdp_rdata == ed, "R9 hdp_rdata", hdp_rdata, ed);
  endtask

  task automatic cyc();
    @(posedge clk); m_step(); @(negedge clk); cmp_all();
  endtask

  task automatic idle();
    cmd_valid = 0; swtr_wr = 0; sw_done = 0; hw_done = 0; err_evt = 0; hdp_wr = 0; close_ack = 0;
  endtask

  task automatic cmd(input logic [2:0] code, input logic [NCH-1:0] arg);
    idle(); cmd_valid = 1; cmd_code = code; cmd_arg = arg;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++; $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(state == 0 && hw_mask == 0 && !close_req && err_stat == 0 && !sw_irq && hw_irq == 0, "R1 reset",
        {state, hw_mask, close_req, err_stat}, 0);
    cmp_all();

    idle(); hw_done = 4'b0101; sw_done = 1; err_evt = 1; err_code = 3'd5; cyc();
    idle(); swtr_wr = 1; hdp_wr = 1; hdp_sel = 2; hdp_wdata = 16'hbeef; cyc();
    chk(sw_start == 1, "R8 trigger in normal", sw_start, 1);
    cmd(5, 4'b0000); cyc();
    idle(); hw_req_in = 4'b1111; cyc();
    chk(hw_req_out == 4'b1111, "R10 unmasked", hw_req_out, 4'b1111);
    sw_busy = 1; hw_busy = 1; hw_ch = 2; cmd(1, 0); cyc();
    chk(state == 1 && !sw_start && !sw_irq && hw_irq == 0 && !err_irq && hw_mask == 4'hf && err_stat == 5,
        "R2 entry", {state, hw_mask, err_stat}, {2'd1, 4'hf, 3'd5});
    idle(); cyc();
    chk(state == 2 && close_req && !close_sw && close_ch == 2 && close_code == 2'b11, "R4 hw first",
        {state, close_req, close_sw, close_ch}, {2'd2, 1'b1, 1'b0, 2'd2});
    sw_busy = 0; hw_busy = 0; cyc();
    chk(close_req && !close_sw && close_ch == 2, "R4 held without ack", {close_req, close_sw}, 2'b10);
    close_ack = 1; cyc();
    chk(close_req && close_sw && close_ch == 0 && err_stat == 3'b011, "R5 first ack",
        {close_req, close_sw, err_stat}, {2'b11, 3'b011});
    cyc();
    chk(!close_req && state == 2, "R5 after last ack", {close_req, state}, {1'b0, 2'd2});
    idle(); cyc();
    chk(state == 3, "R5 standby after drain", state, 3);
    cmd(4, 0); cyc();
    chk(err_stat == 3'b011, "R7 error clear ignored", err_stat, 3'b011);
    idle(); swtr_wr = 1; cyc();
    chk(sw_start == 0, "R8 trigger ignored", sw_start, 0);
    cmd(5, 4'hf); cyc();
    chk(hw_mask == 4'hf, "R9 mask clear ignored", hw_mask, 4'hf);
    idle(); hdp_wr = 1; hdp_sel = 2; hdp_wdata = 16'h1111; cyc();
    cmd(2, 0); cyc();
    chk(state == 0 && hw_mask == 4'hf, "R6 release", {state, hw_mask}, {2'd0, 4'hf});
    idle(); hdp_sel = 2; cyc();
    chk(hdp_rdata == 16'hbeef, "R9 pointer write ignored", hdp_rdata, 16'hbeef);
    chk(hw_req_out == 0, "R10 masked", hw_req_out, 0);
    cmd(4, 0); cyc();
    chk(err_stat == 0 && !err_irq, "R7 clear in normal", err_stat, 0);
    cmd(5, 4'b0011); cyc();
    idle(); cyc();
    chk(hw_req_out == 4'b0011, "R10 partial unmask", hw_req_out, 4'b0011);
    idle(); cyc(); cyc(); cyc();
    chk(state == 0, "R3 stays normal with no command", state, 0);

    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      idle();
      cmd_valid = r < 25; cmd_code = 3'($urandom_range(0, 7)); cmd_arg = NCH'($urandom);
      if (m_st == 0 && cmd_code == 1 && $urandom_range(0, 2) != 0) cmd_valid = 0;
      swtr_wr = $urandom_range(0, 3) == 0; sw_done = $urandom_range(0, 5) == 0;
      hw_done = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
      err_evt = $urandom_range(0, 7) == 0; err_code = 3'($urandom);
      sw_busy = $urandom_range(0, 1) == 1; hw_busy = $urandom_range(0, 1) == 1; hw_ch = CW'($urandom);
      hw_req_in = NCH'($urandom);
      hdp_wr = $urandom_range(0, 3) == 0; hdp_sel = CW'($urandom); hdp_wdata = PW'($urandom);
      close_ack = $urandom_range(0, 2) == 0;
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule